// File: doc/BRIEF.md
# Barrel Multithreaded I/O Processor Sequencer

This block runs ten small I/O processor contexts on one shared execution slot. Each context keeps its own register set: a program counter, a 12-bit accumulator, a latched instruction word and a phase marker that records how far its current instruction has progressed. On every clock the barrel advances by one position. The context now in the slot does one step of its instruction, and its updated registers are written back. The slot never waits. A context that cannot make progress on its turn leaves its registers as they are, and the barrel moves on to the next context.

Each context has a private 12-bit memory. It is reached through one shared memory port, which carries the number of the context in the slot. A central-memory read is issued on one turn, and the reply is taken from the central-memory return inputs on the same context's next turn, ten clocks later. Context 0 usually runs a supervisory polling loop on a mailbox word in its memory. Its program spins on a jump-if-zero until another agent writes a nonzero value to the mailbox.

Top module: `bp_barrel_seq`

## Requirements
- R1: The slot context number counts 0, 1, ..., N_CTX-1, 0, ... and advances by exactly one position on every clock, whatever the contexts are doing. It is 0 on the first clock after reset.
- R2: While reset is held and on the first turn after it, the slot is context 0, it reads its memory at address 0, and it issues no memory write and no central read. Every context starts at program counter 0 in the fetch phase.
- R3: Every instruction takes a fetch turn and then an execute turn of the same context, ten clocks apart. A context that fetches on its turn t executes on its turn t+1.
- R4: The instruction word holds the opcode in bits 11:9 and a zero-extended operand in bits 8:0. The opcodes are 0 load-immediate, 1 load-from-memory, 2 add-from-memory (12-bit wraparound), 3 store, 4 jump, 5 jump-if-accumulator-zero, 6 central read and 7 no-op.
- R5: A store writes the accumulator to the operand address in the memory of the context that owns the slot. It touches no other context's memory.
- R6: A jump sets the program counter to the operand. A jump-if-zero does the same only when the accumulator is zero and otherwise falls through. A jump to its own address parks the context with no further stores.
- R7: A central read raises the request on its execute turn, with the accumulator as the address and the slot number as the tag. On the context's next turn, if the return is valid, the returned word is loaded into the accumulator.
- R8: If the central return is not valid on a waiting context's turn, that context's registers do not change and it tries again one rotation later. Other contexts keep their own timing.
- R9: A single turn never both writes memory and issues a central read.
- R10: Every instruction that does not branch advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one barrel step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_ctx | output | CTX_W | Context occupying the slot this cycle; also tags the memory and central ports |
| mem_en | output | 1 | Memory access by the slot context this cycle |
| mem_we | output | 1 | Write strobe for that access |
| mem_addr | output | 12 | Word address in the slot context's memory |
| mem_wdata | output | 12 | Store data |
| mem_rdata | input | 12 | Read data for mem_addr, valid in the same cycle |
| cm_req | output | 1 | Central-memory read request from the slot context |
| cm_addr | output | 12 | Central-memory read address |
| cm_rdata | input | 12 | Central read reply for the slot context |
| cm_valid | input | 1 | cm_rdata is ready for the slot context this cycle |

## Verification
The embedded assertions check on every cycle that the barrel advances one position with no skips or holds. They also check that memory writes happen only on execute turns, that a store and a central request never share a turn, and that a waiting context whose reply is absent leaves its register set unchanged. The bench scenarios show the things no single-cycle property can see: the exact clock of each store across several rotations, arithmetic wraparound, the mailbox poll falling through once a word arrives, central replies being held back for one or two rotations, and each context's results staying in its own memory.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int WORD_W = 12;
    localparam int OPC_W  = 3;
    localparam int OPD_W  = WORD_W - OPC_W;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LDI = 3'd0,
        OP_LDA = 3'd1,
        OP_ADD = 3'd2,
        OP_STA = 3'd3,
        OP_JMP = 3'd4,
        OP_JZ  = 3'd5,
        OP_CRD = 3'd6,
        OP_NOP = 3'd7
    } op_e;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] ir;
        phase_e            phase;
    } ctx_t;

endpackage

// File: rtl/bp_rotor.sv
module bp_rotor #(
    parameter int N_CTX = 10,
    localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CTX_W-1:0] slot
);
    localparam logic [CTX_W-1:0] LAST = CTX_W'(N_CTX - 1);

    logic [CTX_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;

    // R1
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1)));

endmodule

// File: rtl/bp_ctx_file.sv
module bp_ctx_file
    import bp_pkg::*;
#(
    parameter int N_CTX = 10,
    localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] sel,
    input  ctx_t             wr_data,
    output ctx_t             rd_data
);
    ctx_t ctx_d [N_CTX];
    ctx_t ctx_q [N_CTX];

    always_comb begin
        for (int i = 0; i < N_CTX; i++) begin
            ctx_d[i] = ctx_q[i];
            if (sel == CTX_W'(i)) ctx_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CTX; i++) begin
            if (!rst_n) ctx_q[i] <= '{pc: '0, acc: '0, ir: '0, phase: PH_FETCH};
            else        ctx_q[i] <= ctx_d[i];
        end
    end

    always_comb begin
        rd_data = ctx_q[0];
        for (int i = 0; i < N_CTX; i++) begin
            if (sel == CTX_W'(i)) rd_data = ctx_q[i];
        end
    end

endmodule

// File: rtl/bp_slot_exec.sv
module bp_slot_exec
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_t              cur,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              cm_valid,
    input  logic [WORD_W-1:0] cm_rdata,
    output ctx_t              nxt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              cm_req,
    output logic [WORD_W-1:0] cm_addr
);
    op_e               op;
    logic [WORD_W-1:0] opnd;
    logic [WORD_W-1:0] pc_inc;

    assign op     = op_e'(cur.ir[WORD_W-1:OPD_W]);
    assign opnd   = {{OPC_W{1'b0}}, cur.ir[OPD_W-1:0]};
    assign pc_inc = cur.pc + 1'b1;

    always_comb begin
        nxt       = cur;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur.pc;
        mem_wdata = cur.acc;
        cm_req    = 1'b0;
        cm_addr   = cur.acc;
        unique case (cur.phase)
            PH_FETCH: begin
                mem_en    = 1'b1;
                nxt.ir    = mem_rdata;
                nxt.phase = PH_EXEC;
            end
            PH_EXEC: begin
                nxt.phase = PH_FETCH;
                nxt.pc    = pc_inc;
                unique case (op)
                    OP_LDI: nxt.acc = opnd;
                    OP_LDA: begin
                        mem_en   = 1'b1;
                        mem_addr = opnd;
                        nxt.acc  = mem_rdata;
                    end
                    OP_ADD: begin
                        mem_en   = 1'b1;
                        mem_addr = opnd;
                        nxt.acc  = cur.acc + mem_rdata;
                    end
                    OP_STA: begin
                        mem_en   = 1'b1;
                        mem_we   = 1'b1;
                        mem_addr = opnd;
                    end
                    OP_JMP: nxt.pc = opnd;
                    OP_JZ:  if (cur.acc == '0) nxt.pc = opnd;
                    OP_CRD: begin
                        cm_req    = 1'b1;
                        nxt.phase = PH_WAIT;
                    end
                    default: ;
                endcase
            end
            PH_WAIT: begin
                if (cm_valid) begin
                    nxt.acc   = cm_rdata;
                    nxt.phase = PH_FETCH;
                end
            end
            default: nxt.phase = PH_FETCH;
        endcase
    end

    // R3
    store_on_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cur.phase == PH_EXEC));

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, cm_req}));

endmodule

// File: rtl/bp_barrel_seq.sv
module bp_barrel_seq
    import bp_pkg::*;
#(
    parameter int N_CTX = 10,
    localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CTX_W-1:0]  slot_ctx,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cm_req,
    output logic [WORD_W-1:0] cm_addr,
    input  logic [WORD_W-1:0] cm_rdata,
    input  logic              cm_valid
);
    logic [CTX_W-1:0] slot;
    ctx_t             cur_ctx;
    ctx_t             nxt_ctx;
    logic             stall;

    bp_rotor #(.N_CTX(N_CTX)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    bp_ctx_file #(.N_CTX(N_CTX)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (slot),
        .wr_data (nxt_ctx),
        .rd_data (cur_ctx)
    );

    bp_slot_exec u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (cur_ctx),
        .mem_rdata (mem_rdata),
        .cm_valid  (cm_valid),
        .cm_rdata  (cm_rdata),
        .nxt       (nxt_ctx),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cm_req    (cm_req),
        .cm_addr   (cm_addr)
    );

    assign slot_ctx = slot;
    assign stall    = (cur_ctx.phase == PH_WAIT) && !cm_valid;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (nxt_ctx == cur_ctx));

endmodule

// File: tb/tb_bp_barrel_seq.sv
module tb_bp_barrel_seq;
    localparam int CLK_P = 10;
    localparam int N     = 10;
    localparam int MD    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot_ctx;
    logic        mem_en, mem_we, cm_req, cm_valid;
    logic [11:0] mem_addr, mem_wdata, mem_rdata, cm_addr, cm_rdata;

    bp_barrel_seq #(.N_CTX(N)) dut (
        .clk(clk), .rst_n(rst_n), .slot_ctx(slot_ctx),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cm_req(cm_req), .cm_addr(cm_addr), .cm_rdata(cm_rdata),
        .cm_valid(cm_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [11:0] bmem [N][MD];
    int          cyc;
    int          slot_err;
    int          wr_cnt [N];
    int          wr_cyc [N];
    logic [11:0] wr_val [N];
    logic [5:0]  wr_adr [N];
    int          cm_cnt [N];
    int          cm_cyc [N];
    logic [11:0] cm_rec [N];
    logic        pend [N];
    logic [11:0] pend_a [N];
    int          deny [N];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    function automatic logic [11:0] ins(int op, int opnd);
        return {op[2:0], opnd[8:0]};
    endfunction

    function automatic int deny_of(int k);
        return (k == 3) ? 2 : ((k == 7) ? 1 : 0);
    endfunction

    // R4: opcodes 0 LDI,1 LDA,2 ADD,3 STA,4 JMP,5 JZ,6 CRD
    function automatic logic [11:0] prog(int k, int a);
        if (k == 0) begin
            case (a)
                0: return ins(1, 50);
                1: return ins(5, 0);
                2: return ins(3, 51);
                3: return ins(4, 3);
                default: return 12'h000;
            endcase
        end else if (k % 2 == 0) begin
            case (a)
                0: return ins(0, 12'h100 + k);
                1: return ins(2, 40);
                2: return ins(3, 41);
                3: return ins(4, 3);
                40: return 12'hF80;
                default: return 12'h000;
            endcase
        end else begin
            case (a)
                0: return ins(0, 12'h040 + k);
                1: return ins(6, 0);
                2: return ins(3, 42);
                3: return ins(4, 3);
                default: return 12'h000;
            endcase
        end
    endfunction

    assign mem_rdata = bmem[slot_ctx][mem_addr[5:0]];
    assign cm_valid  = pend[slot_ctx] && (deny[slot_ctx] == 0);
    assign cm_rdata  = pend_a[slot_ctx] ^ 12'hA5A;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= 0;
            slot_err <= 0;
            for (int k = 0; k < N; k++) begin
                for (int a = 0; a < MD; a++) bmem[k][a] <= prog(k, a);
                wr_cnt[k] <= 0; wr_cyc[k] <= -1; wr_val[k] <= '0; wr_adr[k] <= '0;
                cm_cnt[k] <= 0; cm_cyc[k] <= -1; cm_rec[k] <= '0;
                pend[k]   <= 1'b0; pend_a[k] <= '0; deny[k] <= deny_of(k);
            end
        end else begin
            cyc <= cyc + 1;
            if (int'(slot_ctx) != cyc % N) slot_err <= slot_err + 1;
            if (cyc == 100) bmem[0][50] <= 12'h3C7;
            if (mem_en && mem_we) begin
                bmem[slot_ctx][mem_addr[5:0]] <= mem_wdata;
                wr_cnt[slot_ctx] <= wr_cnt[slot_ctx] + 1;
                wr_cyc[slot_ctx] <= cyc;
                wr_val[slot_ctx] <= mem_wdata;
                wr_adr[slot_ctx] <= mem_addr[5:0];
            end
            if (cm_req) begin
                cm_cnt[slot_ctx] <= cm_cnt[slot_ctx] + 1;
                cm_cyc[slot_ctx] <= cyc;
                cm_rec[slot_ctx] <= cm_addr;
                pend[slot_ctx]   <= 1'b1;
                pend_a[slot_ctx] <= cm_addr;
            end else if (pend[slot_ctx]) begin
                if (deny[slot_ctx] > 0) deny[slot_ctx] <= deny[slot_ctx] - 1;
                else pend[slot_ctx] <= 1'b0;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        chk(slot_ctx == 0, "R2 slot", int'(slot_ctx), 0);
        chk(mem_addr == 0 && mem_en, "R2 fetch addr", int'(mem_addr), 0);
        chk(!mem_we, "R2 no write", int'(mem_we), 0);
        chk(!cm_req, "R2 no central", int'(cm_req), 0);
        rst_n = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        // R1 rotation over all cycles
        chk(slot_err == 0, "R1 rotation", slot_err, 0);
        for (int k = 0; k < N; k++) begin
            int exp_adr, exp_val, exp_cyc;
            if (k == 0) begin
                exp_adr = 51; exp_val = 12'h3C7; exp_cyc = 170;
            end else if (k % 2 == 0) begin
                exp_adr = 41; exp_val = (12'h100 + k + 12'hF80) & 12'hFFF; exp_cyc = k + 50;
            end else begin
                exp_adr = 42; exp_val = (12'h040 + k) ^ 12'hA5A; exp_cyc = k + 60 + 10 * deny_of(k);
            end
            // R5 R6 one store per context, then parked
            chk(wr_cnt[k] == 1, $sformatf("R6 store count ctx%0d", k), wr_cnt[k], 1);
            chk(int'(wr_adr[k]) == exp_adr, $sformatf("R5 store addr ctx%0d", k), int'(wr_adr[k]), exp_adr);
            chk(int'(bmem[k][exp_adr]) == exp_val, $sformatf("R4 R5 R7 value ctx%0d", k),
                int'(bmem[k][exp_adr]), exp_val);
            // R3 R8 R10 store clock
            chk(wr_cyc[k] == exp_cyc, $sformatf("R3 R8 R10 store cycle ctx%0d", k), wr_cyc[k], exp_cyc);
            if (k % 2 == 1) begin
                // R7 central request timing and address
                chk(cm_cnt[k] == 1, $sformatf("R7 req count ctx%0d", k), cm_cnt[k], 1);
                chk(cm_cyc[k] == k + 30, $sformatf("R7 req cycle ctx%0d", k), cm_cyc[k], k + 30);
                chk(int'(cm_rec[k]) == 12'h040 + k, $sformatf("R7 req addr ctx%0d", k),
                    int'(cm_rec[k]), 12'h040 + k);
            end else begin
                chk(cm_cnt[k] == 0, $sformatf("R9 no req ctx%0d", k), cm_cnt[k], 0);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule